// File: doc/BRIEF.md
# Two-Channel Disk Controller PIO Address Router

This block sits on the programmed-I/O path of a two-channel disk controller. Each host access is compared against five base/span windows: command and control windows for each of the two channels, and one shared bus-master register window. The block reports which kind of window was hit, which channel owns the access, the offset inside the window and which of the four attached drives the access is for. It then issues a one-cycle read or write strobe to the register files behind it. Those register files are not part of this block.

Each channel keeps a shadow copy of its drive-select bit. The block captures that bit by watching writes to the drive/head register in the channel's command window. The shadow bit and the channel together give a drive index from 0 to 3. Two enable bits gate the accesses. The I/O enable gates all traffic. The bus-master enable gates only writes into the bus-master window. The window bases can be reprogrammed through a configuration port. Writing all-ones to a base is a size probe and leaves the decoded base unchanged.

All results are registered, so they appear one clock after the access is presented.

Top module: `ata_pio_router`

## Requirements
- R1: An address A hits window w when base(w) <= A < base(w) + span(w). The spans are 8 for command windows, 4 for control windows and 16 for the bus-master window. The reported offset is A - base(w). The hit_kind code is 1 for command, 2 for control and 3 for bus-master. The primary command and control windows report hit_sec=0, and the secondary windows report hit_sec=1.
- R2: When windows overlap, the lowest-numbered window wins. The order is 0 primary command, 1 primary control, 2 secondary command, 3 secondary control, 4 bus-master. An enabled access that hits no window pulses miss_err and issues no strobe.
- R3: In the bus-master window, offsets 0 to 7 belong to the primary channel (hit_sec=0). Offsets 8 to 15 belong to the secondary channel (hit_sec=1).
- R4: An accepted write to offset 6 of a channel's command window copies bit 4 of acc_wdata into that channel's device bit. No other access changes a device bit.
- R5: hit_drive equals {hit_sec, device bit of that channel}. For a drive/head write, the value used is the one that write stores.
- R6: While the I/O enable is 0, an access produces no strobe, no miss_err and no size_err, and it leaves the device bits unchanged.
- R7: While the bus-master enable is 0, a write to the bus-master window produces no strobe. Reads of that window and accesses to other windows are not affected.
- R8: acc_size codes are 0 for byte, 1 for 16-bit and 2 for 32-bit. Code 3 is illegal for every window. Code 2 is illegal for command and control windows. An illegal access pulses size_err, issues no strobe and does not update a device bit.
- R9: A config write with cfg_sel 0 to 4 sets the base of that window, numbered as in R2. A write whose data is all ones is ignored. An access presented in the same cycle as a base write is decoded against the old base.
- R10: Reset clears all five bases, both device bits and both enables, and drives every output to 0.
- R11: Results appear one cycle after the access. Each strobe or flag is high for exactly one cycle per access, and rd_stb and wr_stb are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Base register write |
| cfg_sel | input | 3 | Window number (0-4) for a base write |
| cfg_wdata | input | ADDR_W | New base value; all-ones is a size probe |
| en_we | input | 1 | Load the enable bits |
| en_io | input | 1 | I/O space enable value |
| en_bm | input | 1 | Bus-master enable value |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | 8 | Low byte of write data |
| rd_stb | output | 1 | Read strobe to the selected register file |
| wr_stb | output | 1 | Write strobe to the selected register file |
| hit_kind | output | 2 | 1 command, 2 control, 3 bus-master |
| hit_sec | output | 1 | 0 primary channel, 1 secondary channel |
| hit_off | output | OFF_W | Offset inside the window |
| hit_drive | output | 2 | Selected drive index 0-3 |
| hit_size | output | 2 | Access size passed through |
| hit_wdata | output | 8 | Write data passed through |
| miss_err | output | 1 | Enabled access matched no window |
| size_err | output | 1 | Illegal access width for the window |

## Verification
Two functions can act in the same cycle. In the first case, the drive-select snoop and the decode of the same drive/head write both happen at once. The bench writes to command offset 6 with bit 4 set and cleared. It then checks that the strobe of that same write already carries the new drive index, and that later reads of the other channel keep their own index. In the second case, a base write and an access are presented on one clock edge. The bench checks that the access decodes against the old base and that the next access uses the new one.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_CMD  = 2'd1,
        KIND_CTL  = 2'd2,
        KIND_BM   = 2'd3
    } kind_e;

    localparam int WIN_N    = 5;
    localparam int WIN_PCMD = 0;
    localparam int WIN_PCTL = 1;
    localparam int WIN_SCMD = 2;
    localparam int WIN_SCTL = 3;
    localparam int WIN_BM   = 4;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;

endpackage

// File: rtl/ata_win_cmp.sv
module ata_win_cmp #(
    parameter int ADDR_W = 16,
    parameter int SPAN   = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] off
);
    localparam int EW = ADDR_W + 1;
    localparam logic [EW-1:0] SPAN_E = EW'(SPAN);

    logic [EW-1:0] lo_e;
    logic [EW-1:0] hi_e;
    logic [EW-1:0] a_e;

    always_comb begin
        lo_e = {1'b0, base};
        hi_e = lo_e + SPAN_E;
        a_e  = {1'b0, addr};
        hit  = (a_e >= lo_e) && (a_e < hi_e);
        off  = addr - base;
    end
endmodule

// File: rtl/ata_win_prio.sv
module ata_win_prio
    import ata_pio_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BM_SPLIT = 8
) (
    input  logic [WIN_N-1:0]             hit,
    input  logic [WIN_N-1:0][ADDR_W-1:0] off_all,
    output logic                         any,
    output kind_e                        kind,
    output logic                         sec,
    output logic [ADDR_W-1:0]            off
);
    logic [2:0] sel;

    always_comb begin
        sel = 3'd0;
        for (int i = WIN_N - 1; i >= 0; i--) begin
            if (hit[i]) sel = 3'(i);
        end
        any = |hit;
        off = off_all[sel];
        unique case (sel)
            3'(WIN_PCMD): begin kind = KIND_CMD; sec = 1'b0; end
            3'(WIN_PCTL): begin kind = KIND_CTL; sec = 1'b0; end
            3'(WIN_SCMD): begin kind = KIND_CMD; sec = 1'b1; end
            3'(WIN_SCTL): begin kind = KIND_CTL; sec = 1'b1; end
            default: begin
                kind = KIND_BM;
                sec  = (off >= ADDR_W'(BM_SPLIT));
            end
        endcase
        if (!any) kind = KIND_NONE;
    end
endmodule

// File: rtl/ata_pio_router.sv
module ata_pio_router
    import ata_pio_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CMD_SPAN = 8,
    parameter int CTL_SPAN = 4,
    parameter int BM_SPAN  = 16,
    parameter int BM_SPLIT = 8,
    parameter int DH_OFF   = 6,
    parameter int DSEL_BIT = 4,
    localparam int MAX_SPAN = (BM_SPAN > CMD_SPAN)
                              ? ((BM_SPAN > CTL_SPAN) ? BM_SPAN : CTL_SPAN)
                              : ((CMD_SPAN > CTL_SPAN) ? CMD_SPAN : CTL_SPAN),
    localparam int OFF_W = (MAX_SPAN > 1) ? $clog2(MAX_SPAN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              en_we,
    input  logic              en_io,
    input  logic              en_bm,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [1:0]        hit_kind,
    output logic              hit_sec,
    output logic [OFF_W-1:0]  hit_off,
    output logic [1:0]        hit_drive,
    output logic [1:0]        hit_size,
    output logic [7:0]        hit_wdata,
    output logic              miss_err,
    output logic              size_err
);
    typedef struct packed {
        logic [WIN_N-1:0][ADDR_W-1:0] base;
        logic                         io;
        logic                         bm;
        logic [1:0]                   dev;
        logic                         rd;
        logic                         wr;
        logic                         miss;
        logic                         szerr;
        kind_e                        kind;
        logic                         sec;
        logic [OFF_W-1:0]             off;
        logic [1:0]                   drive;
        logic [1:0]                   size;
        logic [7:0]                   wdata;
    } state_t;

    state_t s_d, s_q;

    logic [WIN_N-1:0]             win_hit;
    logic [WIN_N-1:0][ADDR_W-1:0] win_off;
    logic                         dec_any;
    kind_e                        dec_kind;
    logic                         dec_sec;
    logic [ADDR_W-1:0]            dec_off;
    logic                         io_on;
    logic                         bm_on;

    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        localparam int SP = (w == WIN_BM) ? BM_SPAN
                          : ((w % 2) == 0) ? CMD_SPAN : CTL_SPAN;
        ata_win_cmp #(.ADDR_W(ADDR_W), .SPAN(SP)) u_cmp (
            .base (s_q.base[w]),
            .addr (acc_addr),
            .hit  (win_hit[w]),
            .off  (win_off[w])
        );
    end

    ata_win_prio #(.ADDR_W(ADDR_W), .BM_SPLIT(BM_SPLIT)) u_prio (
        .hit     (win_hit),
        .off_all (win_off),
        .any     (dec_any),
        .kind    (dec_kind),
        .sec     (dec_sec),
        .off     (dec_off)
    );

    always_comb begin
        logic       illegal;
        logic [1:0] dev_n;
        s_d       = s_q;
        s_d.rd    = 1'b0;
        s_d.wr    = 1'b0;
        s_d.miss  = 1'b0;
        s_d.szerr = 1'b0;
        illegal   = (acc_size == SZ_BAD) ||
                    ((dec_kind != KIND_BM) && (acc_size == SZ_WORD));
        dev_n     = s_q.dev;

        if (cfg_we && (int'(cfg_sel) < WIN_N) && (cfg_wdata != {ADDR_W{1'b1}}))
            s_d.base[cfg_sel] = cfg_wdata;

        if (en_we) begin
            s_d.io = en_io;
            s_d.bm = en_bm;
        end

        if (acc_valid && s_q.io) begin
            if (!dec_any) begin
                s_d.miss = 1'b1;
            end else if (illegal) begin
                s_d.szerr = 1'b1;
            end else begin
                if (acc_write && (dec_kind == KIND_CMD) &&
                    (dec_off == ADDR_W'(DH_OFF)))
                    dev_n[dec_sec] = acc_wdata[DSEL_BIT];
                s_d.dev = dev_n;
                if (acc_write)
                    s_d.wr = (dec_kind != KIND_BM) || s_q.bm;
                else
                    s_d.rd = 1'b1;
                if (s_d.wr || s_d.rd) begin
                    s_d.kind  = dec_kind;
                    s_d.sec   = dec_sec;
                    s_d.off   = dec_off[OFF_W-1:0];
                    s_d.drive = {dec_sec, dev_n[dec_sec]};
                    s_d.size  = acc_size;
                    s_d.wdata = acc_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign io_on     = s_q.io;
    assign bm_on     = s_q.bm;
    assign rd_stb    = s_q.rd;
    assign wr_stb    = s_q.wr;
    assign hit_kind  = s_q.kind;
    assign hit_sec   = s_q.sec;
    assign hit_off   = s_q.off;
    assign hit_drive = s_q.drive;
    assign hit_size  = s_q.size;
    assign hit_wdata = s_q.wdata;
    assign miss_err  = s_q.miss;
    assign size_err  = s_q.szerr;
endmodule

// File: rtl/ata_pio_router_chk.sv
module ata_pio_router_chk #(
    parameter int OFF_W    = 4,
    parameter int CMD_SPAN = 8,
    parameter int CTL_SPAN = 4,
    parameter int BM_SPLIT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_on,
    input logic             bm_on,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic [1:0]       hit_kind,
    input logic             hit_sec,
    input logic [OFF_W-1:0] hit_off,
    input logic [1:0]       hit_drive,
    input logic             miss_err,
    input logic             size_err
);
    a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        miss_err |-> (!rd_stb && !wr_stb && !size_err));

    a_r8_size_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> (!rd_stb && !wr_stb && !miss_err));

    a_r6_io_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_on |=> (!rd_stb && !wr_stb && !miss_err && !size_err));

    a_r11_no_result_without_access: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!rd_stb && !wr_stb && !miss_err && !size_err));

    a_r3_bm_split: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && hit_kind == 2'd3) |->
            (hit_sec == (int'(hit_off) >= BM_SPLIT)));

    a_r5_drive_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> (hit_drive[1] == hit_sec));

    a_r7_bm_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!bm_on && acc_valid && acc_write) |=> !(wr_stb && hit_kind == 2'd3));

    a_r1_offset_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |->
            ((hit_kind == 2'd1 && int'(hit_off) < CMD_SPAN) ||
             (hit_kind == 2'd2 && int'(hit_off) < CTL_SPAN) ||
             (hit_kind == 2'd3)));
endmodule

bind ata_pio_router ata_pio_router_chk #(
    .OFF_W(OFF_W), .CMD_SPAN(CMD_SPAN), .CTL_SPAN(CTL_SPAN), .BM_SPLIT(BM_SPLIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_on(io_on), .bm_on(bm_on),
    .acc_valid(acc_valid), .acc_write(acc_write),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .hit_kind(hit_kind), .hit_sec(hit_sec),
    .hit_off(hit_off), .hit_drive(hit_drive),
    .miss_err(miss_err), .size_err(size_err)
);

// File: tb/ata_pio_router_tb.sv
`timescale 1ns/1ps
module ata_pio_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        en_we = 1'b0, en_io = 1'b0, en_bm = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_size = '0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        rd_stb, wr_stb, hit_sec, miss_err, size_err;
    logic [1:0]  hit_kind, hit_drive, hit_size;
    logic [3:0]  hit_off;
    logic [7:0]  hit_wdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] bb [5];
    logic        b_io = 0, b_bm = 0;
    logic [1:0]  b_dev = '0;

    always #2.5 clk = ~clk;

    ata_pio_router u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .en_we(en_we), .en_io(en_io), .en_bm(en_bm),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .hit_kind(hit_kind), .hit_sec(hit_sec),
        .hit_off(hit_off), .hit_drive(hit_drive), .hit_size(hit_size),
        .hit_wdata(hit_wdata), .miss_err(miss_err), .size_err(size_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int span_of(input int w);
        return (w == 4) ? 16 : ((w % 2) == 0) ? 8 : 4;
    endfunction

    task automatic set_base(input int w, input logic [15:0] v);
        cfg_we = 1'b1; cfg_sel = 3'(w); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (w < 5 && v != 16'hFFFF) bb[w] = v;
    endtask

    task automatic set_en(input logic io, input logic bm);
        en_we = 1'b1; en_io = io; en_bm = bm;
        @(negedge clk);
        en_we = 1'b0; b_io = io; b_bm = bm;
    endtask

    // model of R1-R8, then one access, then compare one cycle later (R11)
    task automatic probe(input logic w, input logic [1:0] sz, input logic [15:0] a,
                         input logic [7:0] d, input string req);
        logic e_rd = 0, e_wr = 0, e_miss = 0, e_sz = 0, e_sec = 0;
        logic [1:0] e_kind = 0, e_drv = 0;
        int win = -1, off = 0;
        for (int i = 4; i >= 0; i--)
            if (int'(a) >= int'(bb[i]) && int'(a) < int'(bb[i]) + span_of(i)) win = i;
        if (b_io) begin
            if (win < 0) e_miss = 1;
            else begin
                off    = int'(a) - int'(bb[win]);
                e_kind = (win == 4) ? 2'd3 : ((win % 2) == 0) ? 2'd1 : 2'd2;
                e_sec  = (win == 4) ? (off >= 8) : (win >= 2);
                if (sz == 2'd3 || (win != 4 && sz == 2'd2)) e_sz = 1;
                else begin
                    if (w && e_kind == 2'd1 && off == 6) b_dev[e_sec] = d[4];
                    e_drv = {e_sec, b_dev[e_sec]};
                    if (w) e_wr = (win != 4) || b_bm;
                    else   e_rd = 1;
                end
            end
        end
        acc_valid = 1'b1; acc_write = w; acc_size = sz; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, {28'd0, rd_stb, wr_stb, miss_err, size_err}, {28'd0, e_rd, e_wr, e_miss, e_sz});
        if (e_rd || e_wr)
            check(req, {21'd0, hit_kind, hit_sec, hit_off, hit_drive, hit_size},
                       {21'd0, e_kind, e_sec, 4'(off), e_drv, sz});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) bb[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: outputs cleared by reset
        check("R10", {16'd0, rd_stb, wr_stb, miss_err, size_err, hit_kind, hit_sec,
                      hit_off, hit_drive, hit_size}, 32'd0);
        // R6: I/O disabled, a drive/head write must not move the device bit
        probe(1, 0, 16'h0006, 8'h10, "R6");
        probe(0, 0, 16'h9999, 8'h00, "R6");
        set_en(1, 0);
        // R10/R2: all bases zero, primary command wins; drive 0 shows R6 left bit alone
        probe(0, 0, 16'h0003, 8'h00, "R10");
        probe(0, 0, 16'h0040, 8'h00, "R2");
        set_base(0, 16'h0120);
        set_base(1, 16'h0130);
        set_base(2, 16'h0140);
        set_base(3, 16'h0148);
        set_base(4, 16'h0160);
        // R9: all-ones probe ignored
        set_base(0, 16'hFFFF);
        probe(0, 0, 16'h0120, 8'h00, "R9");
        // R1/R2/R3: sweep across every window edge
        for (int a = 16'h0110; a < 16'h0180; a++) begin
            string r;
            r = (a >= 'h160 && a < 'h170) ? "R3" :
                ((a >= 'h120 && a < 'h128) || (a >= 'h130 && a < 'h134) ||
                 (a >= 'h140 && a < 'h14C)) ? "R1" : "R2";
            probe(0, 1, 16'(a), 8'h00, r);
        end
        // R8: width rules
        probe(0, 2, 16'h0121, 8'h00, "R8");
        probe(0, 1, 16'h0131, 8'h00, "R8");
        probe(0, 2, 16'h0164, 8'h00, "R8");
        probe(0, 3, 16'h0164, 8'h00, "R8");
        // R4/R5: drive/head snoop, same-cycle drive index
        probe(1, 0, 16'h0126, 8'h10, "R5");
        probe(0, 0, 16'h0140, 8'h00, "R4");
        probe(1, 0, 16'h0146, 8'hFF, "R5");
        probe(0, 0, 16'h0121, 8'h00, "R4");
        probe(1, 0, 16'h0126, 8'hEF, "R5");
        probe(1, 0, 16'h0125, 8'h10, "R4");
        probe(0, 0, 16'h0120, 8'h00, "R4");
        probe(1, 0, 16'h0136, 8'h10, "R4");
        probe(0, 0, 16'h0120, 8'h00, "R4");
        probe(1, 2, 16'h0146, 8'h00, "R8");
        probe(0, 0, 16'h0141, 8'h00, "R8");
        probe(0, 0, 16'h014A, 8'h00, "R5");
        // R7: bus-master write gating
        probe(1, 0, 16'h0160, 8'h01, "R7");
        probe(0, 0, 16'h0168, 8'h00, "R7");
        probe(1, 0, 16'h0122, 8'h01, "R7");
        set_en(1, 1);
        probe(1, 0, 16'h0160, 8'h01, "R7");
        probe(1, 2, 16'h016C, 8'h04, "R7");
        // R2: overlapping windows
        set_base(1, 16'h0124);
        for (int a = 16'h011C; a < 16'h0130; a++) probe(0, 0, 16'(a), 8'h00, "R2");
        // R9: base write and access in the same cycle
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'h0200;
        acc_valid = 1'b1; acc_write = 1'b0; acc_size = 0; acc_addr = 16'h0121;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        check("R9", {28'd0, rd_stb, hit_kind, hit_sec}, {28'd0, 1'b1, 2'd1, 1'b0});
        check("R9", {28'd0, hit_off}, 32'd1);
        bb[0] = 16'h0200;
        probe(0, 0, 16'h0203, 8'h00, "R9");
        probe(0, 0, 16'h0121, 8'h00, "R9");
        // R11: idle cycle after an access shows no strobe
        probe(0, 0, 16'h0201, 8'h00, "R11");
        @(negedge clk);
        check("R11", {28'd0, rd_stb, wr_stb, miss_err, size_err}, 32'd0);
        // R6: disable I/O again
        set_en(0, 1);
        probe(1, 0, 16'h0206, 8'h00, "R6");
        set_en(1, 1);
        probe(0, 0, 16'h0200, 8'h00, "R6");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule